// File: doc/BRIEF.md
# Flash Write-Protection Controller

This block sits between the command decoder of a serial flash and its array engine and decides, per command, whether a write-class operation may go ahead. It owns the status byte: the status-lock bit, the protect-direction bit, the three-bit protect-size field, the write-enable latch and the busy flag. A decoded command arrives as a valid/ready transfer carrying an opcode, a 24-bit address and one data byte. One cycle later the block returns a one-cycle verdict (accept or reject) and the status byte already shows any change the command made.

Inputs from the environment are the active-low write-protect pin, a supply-good level and a completion strobe from the array. After the supply becomes good, an inhibit window of `TPUW_CYCLES` clock cycles blocks all write-class commands. While the supply is not good, every command is refused. Protection is set by the direction bit and the size field. The size field selects a power-of-two number of 64 KB blocks, counted from the top or from the bottom of a 2 MB array.

Back-pressure: `cmd_ready` is low while BUSY is 1. A command that meets low ready must be held, with its fields unchanged, until a cycle in which ready is high. The transfer happens on the rising edge where `cmd_valid` and `cmd_ready` are both 1. The response channel has no ready and cannot be stalled.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the status byte is 00h. The layout is fixed: bit 7 status-lock, bit 6 always 0, bit 5 direction, bits 4..2 size field, bit 1 write-enable latch (WEL), bit 0 BUSY. Writing 1 into bit 6 with a status write still reads back 0.
- R2: Opcode 06h sets WEL, provided the inhibit window has ended. Opcode 04h clears WEL and is always accepted while the supply is good.
- R3: Status write (01h), page program (02h), sector erase (20h), block erase (D8h) and chip erase (C7h) are rejected when WEL is 0.
- R4: A status write is rejected when the status-lock bit is 1 and `wp_n` is 0. When the lock bit is 0, `wp_n` has no effect. An accepted status write loads bits 7, 5, 4, 3 and 2 from `cmd_data`.
- R5: With direction 0 and size field s from 1 to 5, the top 2^(s-1) blocks are protected. Block index = address bits 20..16. A program or erase that addresses one of these blocks is rejected.
- R6: With direction 1, the same sizes are protected starting from block 0. Size 0 protects nothing. A size field of 6 or 7 protects every block, whatever the direction bit.
- R7: Chip erase is rejected whenever the size field is not 0.
- R8: For `TPUW_CYCLES` cycles after the supply becomes good (and after reset), opcode 06h and all write-class opcodes are rejected. Opcode 04h is accepted during this window.
- R9: While `pwr_ok` is 0, every command is rejected, WEL and BUSY are cleared, and the inhibit window starts again. The protection bits are kept.
- R10: An accepted write-class command sets BUSY and drops `cmd_ready`. A `wr_done` pulse while BUSY is 1 clears both BUSY and WEL.
- R11: `rsp_valid` pulses in the cycle after each transfer, and `rsp_accept` gives the verdict. Any other opcode is accepted with no change to the status.
- R12: A rejected write-class command leaves the status byte unchanged and does not set BUSY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also restores factory protection values |
| pwr_ok | input | 1 | Supply-good level |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | Decoded command present |
| cmd_ready | output | 1 | Block can take a command (low while BUSY) |
| cmd_op | input | 8 | Opcode |
| cmd_addr | input | ADDR_W | Byte address for program/erase |
| cmd_data | input | 8 | New status value for a status write |
| wr_done | input | 1 | Array reports the running write finished |
| rsp_valid | output | 1 | Verdict valid, one cycle after a transfer |
| rsp_accept | output | 1 | 1 = command accepted, 0 = rejected |
| status | output | 8 | Status byte |

## Verification
The assertions assume the following about the inputs:
- `wr_done` only matters while BUSY is 1.
- Command fields stay stable across a stalled transfer.
- Reset is applied before `pwr_ok` matters.

The stimulus respects these assumptions. The directed tests only issue commands while idle. The random phase holds a stalled command unchanged until the reference model records the transfer. The random phase also keeps supply drops rare and short, so that most commands fall outside the inhibit window.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [7:0] {
    OP_WRSR    = 8'h01,
    OP_PROG    = 8'h02,
    OP_WRDI    = 8'h04,
    OP_WREN    = 8'h06,
    OP_SECT_ER = 8'h20,
    OP_CHIP_ER = 8'hC7,
    OP_BLK_ER  = 8'hD8
  } wp_op_e;

  typedef struct packed {
    logic       lock;
    logic       dir;
    logic [2:0] size;
    logic       wel;
    logic       busy;
  } wp_stat_t;

  function automatic logic [7:0] pack_status(input wp_stat_t s);
    return {s.lock, 1'b0, s.dir, s.size, s.wel, s.busy};
  endfunction

endpackage

// File: rtl/wp_inhibit_timer.sv
module wp_inhibit_timer #(
  parameter int unsigned TPUW_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  output logic inhibit
);
  localparam int CNT_W = $clog2(TPUW_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TPUW_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!pwr_ok)       cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign inhibit = (cnt_q != LIMIT);

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  a_r9_restart_window: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> inhibit);

endmodule

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 21,
  parameter int BLOCK_AW = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              dir,
  input  logic [2:0]        size,
  output logic              addr_prot,
  output logic              any_prot
);
  localparam int NB_W = ARRAY_AW - BLOCK_AW;
  localparam logic [NB_W:0] NBLK = (NB_W+1)'(1) << NB_W;

  logic [NB_W-1:0] blk;
  logic [NB_W:0]   span;
  logic [NB_W:0]   blk_x;

  assign blk   = addr[ARRAY_AW-1:BLOCK_AW];
  assign blk_x = {1'b0, blk};

  always_comb begin
    if (size == 3'd0)
      span = '0;
    else if (size[2:1] == 2'b11 || (int'(size) - 1) >= NB_W)
      span = NBLK;
    else
      span = (NB_W+1)'(1) << (size - 3'd1);
  end

  always_comb begin
    if (span == '0)      addr_prot = 1'b0;
    else if (dir)        addr_prot = (blk_x < span);
    else                 addr_prot = (blk_x >= (NBLK - span));
  end

  assign any_prot = (size != 3'd0);

  always_comb begin
    if (size != 3'd0 && !dir && blk == '1)
      a_r5_top_block_covered: assert (addr_prot);
    if (size != 3'd0 && dir && blk == '0)
      a_r6_bottom_block_covered: assert (addr_prot);
  end

endmodule

// File: rtl/wp_status_regs.sv
module wp_status_regs
  import wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       set_busy,
  input  logic       load_cfg,
  input  logic [7:0] cfg_in,
  input  logic       wr_done,
  output wp_stat_t   stat
);
  wp_stat_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (!pwr_ok) begin
      st_q.wel  <= 1'b0;
      st_q.busy <= 1'b0;
    end else begin
      if (st_q.busy && wr_done) begin
        st_q.busy <= 1'b0;
        st_q.wel  <= 1'b0;
      end
      if (set_busy) st_q.busy <= 1'b1;
      if (set_wel)  st_q.wel  <= 1'b1;
      if (clr_wel)  st_q.wel  <= 1'b0;
      if (load_cfg) begin
        st_q.lock <= cfg_in[7];
        st_q.dir  <= cfg_in[5];
        st_q.size <= cfg_in[4:2];
      end
    end
  end

  assign stat = st_q;

  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.busy && wr_done |=> !st_q.busy && !st_q.wel);

  a_r9_power_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !st_q.busy && !st_q.wel);

  a_r9_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> $stable({st_q.lock, st_q.dir, st_q.size}));

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wp_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          ARRAY_AW    = 21,
  parameter int          BLOCK_AW    = 16,
  parameter int unsigned TPUW_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              wp_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              wr_done,
  output logic              rsp_valid,
  output logic              rsp_accept,
  output logic [7:0]        status
);
  wp_stat_t stat;
  logic inhibit, addr_prot, any_prot;
  logic cmd_fire, grant, gate_ok, is_gated;
  logic set_wel, clr_wel, set_busy, load_cfg;
  logic rsp_valid_q, rsp_accept_q;

  wp_inhibit_timer #(.TPUW_CYCLES(TPUW_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .inhibit(inhibit)
  );

  wp_region_decode #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .BLOCK_AW(BLOCK_AW)) u_region (
    .addr(cmd_addr), .dir(stat.dir), .size(stat.size),
    .addr_prot(addr_prot), .any_prot(any_prot)
  );

  assign cmd_ready = !stat.busy;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign gate_ok   = !inhibit && stat.wel;

  always_comb begin
    grant    = 1'b0;
    is_gated = 1'b0;
    if (pwr_ok) begin
      case (cmd_op)
        OP_WREN:    grant = !inhibit;
        OP_WRDI:    grant = 1'b1;
        OP_WRSR: begin
          is_gated = 1'b1;
          grant    = gate_ok && !(stat.lock && !wp_n);
        end
        OP_PROG, OP_SECT_ER, OP_BLK_ER: begin
          is_gated = 1'b1;
          grant    = gate_ok && !addr_prot;
        end
        OP_CHIP_ER: begin
          is_gated = 1'b1;
          grant    = gate_ok && !any_prot;
        end
        default:    grant = 1'b1;
      endcase
    end
  end

  assign set_wel  = cmd_fire && grant && (cmd_op == OP_WREN);
  assign clr_wel  = cmd_fire && grant && (cmd_op == OP_WRDI);
  assign set_busy = cmd_fire && grant && is_gated;
  assign load_cfg = cmd_fire && grant && (cmd_op == OP_WRSR);

  wp_status_regs u_regs (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .set_wel(set_wel), .clr_wel(clr_wel), .set_busy(set_busy),
    .load_cfg(load_cfg), .cfg_in(cmd_data), .wr_done(wr_done),
    .stat(stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_accept_q <= 1'b0;
    end else begin
      rsp_valid_q  <= cmd_fire;
      rsp_accept_q <= cmd_fire && grant;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_accept = rsp_accept_q;
  assign status     = pack_status(stat);

  a_r3_no_write_without_wel: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !stat.wel && is_gated |=> rsp_valid && !rsp_accept);

  a_r4_lock_blocks_status_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_op == OP_WRSR && stat.lock && !wp_n |=> !rsp_accept);

  a_r7_chip_erase_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_op == OP_CHIP_ER && stat.size != 3'd0 |=> !rsp_accept);

  a_r9_reject_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !pwr_ok |=> !rsp_accept);

  a_r10_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept && $past(is_gated) |-> status[0] && !cmd_ready);

  a_r12_reject_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_accept |-> cmd_ready);

endmodule

// File: tb/wprot_ctrl_tb_top.sv
module wprot_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPUW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_ok = 1'b1, wp_n = 1'b1;
  logic cmd_valid = 1'b0, wr_done = 1'b0;
  logic [7:0] cmd_op = 8'h00, cmd_data = 8'h00;
  logic [23:0] cmd_addr = '0;
  logic cmd_ready, rsp_valid, rsp_accept;
  logic [7:0] status;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wprot_ctrl #(.TPUW_CYCLES(TPUW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wr_done(wr_done),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .status(status)
  );

  // behavioural reference model
  bit m_lock, m_dir, m_wel, m_busy, m_rv, m_ra, m_fired;
  int m_size, m_cnt;

  function automatic bit prot(input int size, input bit dir, input logic [23:0] a);
    int blk, n;
    blk = int'(a[20:16]);
    if (size == 0) return 0;
    if (size >= 6) return 1;
    n = 1 << (size - 1);
    return dir ? (blk < n) : (blk >= 32 - n);
  endfunction

  function automatic int mstat();
    return (int'(m_lock) << 7) | (int'(m_dir) << 5) | (m_size << 2) |
           (int'(m_wel) << 1) | int'(m_busy);
  endfunction

  always @(posedge clk) begin
    bit inh, acc, wr;
    m_fired = 0;
    if (!rst_n) begin
      m_lock = 0; m_dir = 0; m_size = 0; m_wel = 0; m_busy = 0;
      m_cnt = 0; m_rv = 0; m_ra = 0;
    end else begin
      m_rv = 0; m_ra = 0;
      if (cmd_valid && !m_busy) begin
        m_fired = 1; m_rv = 1;
      end
      if (!pwr_ok) begin
        m_cnt = 0; m_wel = 0; m_busy = 0;
      end else begin
        inh = (m_cnt < TPUW);
        if (m_cnt < TPUW) m_cnt++;
        if (m_busy && wr_done) begin m_busy = 0; m_wel = 0; end
        if (m_fired) begin
          wr = 0;
          case (cmd_op)
            8'h06: begin acc = !inh; if (acc) m_wel = 1; end
            8'h04: begin acc = 1; m_wel = 0; end
            8'h01: begin
              wr = 1;
              acc = !inh && m_wel && !(m_lock && !wp_n);
              if (acc) begin
                m_lock = cmd_data[7]; m_dir = cmd_data[5]; m_size = int'(cmd_data[4:2]);
              end
            end
            8'h02, 8'h20, 8'hD8: begin
              wr = 1; acc = !inh && m_wel && !prot(m_size, m_dir, cmd_addr);
            end
            8'hC7: begin wr = 1; acc = !inh && m_wel && (m_size == 0); end
            default: acc = 1;
          endcase
          if (acc && wr) m_busy = 1;
          m_ra = acc;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk({cur_req, " model status"}, int'(status), mstat());
      chk({cur_req, " model ready"}, int'(cmd_ready), int'(!m_busy));
      chk({cur_req, " model rsp_valid"}, int'(rsp_valid), int'(m_rv));
      if (m_rv) chk({cur_req, " model rsp_accept"}, int'(rsp_accept), int'(m_ra));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic issue(input logic [7:0] op, input logic [23:0] a, input logic [7:0] d);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input bit acc, input int st);
    chk({tag, " accept"}, int'(rsp_accept), int'(acc));
    chk({tag, " status"}, int'(status), st);
  endtask

  task automatic finish_write();
    wr_done = 1'b1;
    @(posedge clk); #1;
    wr_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    cur_req = "R1";
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset ready", int'(cmd_ready), 1);

    cur_req = "R8";
    issue(8'h06, 0, 0); expect_rsp("R8 wren in window", 0, 8'h00);
    issue(8'h04, 0, 0); expect_rsp("R8 wrdi in window", 1, 8'h00);
    idle(TPUW + 2);

    cur_req = "R3";
    issue(8'h02, 24'h000100, 0); expect_rsp("R3 prog without wel", 0, 8'h00);
    issue(8'h01, 0, 8'h84);      expect_rsp("R3 wrsr without wel", 0, 8'h00);

    cur_req = "R2";
    issue(8'h06, 0, 0); expect_rsp("R2 wren", 1, 8'h02);
    issue(8'h04, 0, 0); expect_rsp("R2 wrdi", 1, 8'h00);
    issue(8'h06, 0, 0);

    cur_req = "R10";
    issue(8'h01, 0, 8'h84); expect_rsp("R10 wrsr busy", 1, 8'h87);
    chk("R10 ready low", int'(cmd_ready), 0);
    finish_write();
    chk("R10 done clears", int'(status), 8'h84);

    cur_req = "R5";
    issue(8'h06, 0, 0);
    issue(8'h02, 24'h1F0010, 0); expect_rsp("R5/R12 top block", 0, 8'h86);
    issue(8'h02, 24'h1E0000, 0); expect_rsp("R5 block 30 open", 1, 8'h87);
    finish_write();

    cur_req = "R4";
    issue(8'h06, 0, 0);
    wp_n = 1'b0;
    issue(8'h01, 0, 8'h2C); expect_rsp("R4 locked", 0, 8'h86);
    wp_n = 1'b1;
    issue(8'h01, 0, 8'h2C); expect_rsp("R4 pin high", 1, 8'h2F);
    finish_write();

    cur_req = "R6";
    issue(8'h06, 0, 0);
    issue(8'h20, 24'h03FFFF, 0); expect_rsp("R6 lower block 3", 0, 8'h2E);
    issue(8'hD8, 24'h040000, 0); expect_rsp("R6 block 4 open", 1, 8'h2F);
    finish_write();

    cur_req = "R7";
    issue(8'h06, 0, 0);
    issue(8'hC7, 0, 0); expect_rsp("R7 chip erase blocked", 0, 8'h2E);
    issue(8'h01, 0, 8'h18); expect_rsp("R6 set size 6", 1, 8'h1B);
    finish_write();
    cur_req = "R6";
    issue(8'h06, 0, 0);
    issue(8'h02, 24'h100000, 0); expect_rsp("R6 all protected", 0, 8'h1A);
    cur_req = "R1";
    issue(8'h01, 0, 8'h40); expect_rsp("R1 bit6 reads 0", 1, 8'h03);
    finish_write();
    cur_req = "R7";
    issue(8'h06, 0, 0);
    issue(8'hC7, 0, 0); expect_rsp("R7 chip erase open", 1, 8'h03);
    finish_write();

    cur_req = "R4";
    issue(8'h06, 0, 0);
    wp_n = 1'b0;
    issue(8'h01, 0, 8'h00); expect_rsp("R4 no lock pin ignored", 1, 8'h03);
    finish_write();
    wp_n = 1'b1;

    cur_req = "R11";
    issue(8'h03, 24'h123456, 0); expect_rsp("R11 other opcode", 1, 8'h00);
    chk("R11 rsp_valid", int'(rsp_valid), 1);
    idle(1);
    chk("R11 rsp_valid one cycle", int'(rsp_valid), 0);

    cur_req = "R9";
    issue(8'h06, 0, 0);
    pwr_ok = 1'b0;
    idle(1);
    chk("R9 wel cleared", int'(status), 8'h00);
    issue(8'h04, 0, 0); expect_rsp("R9 reject unpowered", 0, 8'h00);
    pwr_ok = 1'b1;
    cur_req = "R8";
    issue(8'h06, 0, 0); expect_rsp("R8 window restarted", 0, 8'h00);
    idle(TPUW + 2);

    cur_req = "R12";
    for (int i = 0; i < 4000; i++) begin
      if (!(cmd_valid && !m_fired)) begin
        int k;
        k = $urandom_range(0, 9);
        cmd_valid = ($urandom_range(0, 1) == 1);
        case (k)
          0, 1: cmd_op = 8'h06;
          2: cmd_op = 8'h04;
          3: cmd_op = 8'h01;
          4: cmd_op = 8'h02;
          5: cmd_op = 8'h20;
          6: cmd_op = 8'hD8;
          7: cmd_op = 8'hC7;
          default: cmd_op = 8'h03;
        endcase
        cmd_addr = 24'($urandom);
        cmd_data = 8'($urandom);
      end
      wp_n    = ($urandom_range(0, 3) != 0);
      wr_done = m_busy && ($urandom_range(0, 3) == 0);
      pwr_ok  = ($urandom_range(0, 499) != 0);
      @(posedge clk); #1;
    end
    cmd_valid = 1'b0; wr_done = 1'b0; pwr_ok = 1'b1;
    idle(2);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule